// File: doc/BRIEF.md
# Bus Adapter Control, Status and Error Capture

This block is the register file of a bus adapter. It sits between the host, which reads and writes longword-addressed registers, and the adapter's translator and system-bus interface, which report error events. It keeps a control/status word with five sticky error flags, an error-interrupt enable and a synthesised summary flag. It also keeps a vector offset, the failing peripheral-bus address, the failing system-bus address and a bank of datapath descriptor slots.

When the first instance of an error arrives, the block latches it and raises the adapter interrupt request if interrupts are enabled. A later instance of the same error changes nothing until software clears the flag.

Software can start an adapter reset by writing the init command bit. The block then runs two timed phases. In the first phase, every offset from the status register upward is blanked. In the second phase, the peripheral bus is held in init. A peripheral power-good flag drops when the sequence starts and returns when the second phase ends.

Top module: `busadp_ctl_regs`

## Requirements
- R1: After reset the interrupt request is low, the power-good output is high, the init output is low, the read data is zero, and the status word (longword offset 0x1C8) reads 0x0000_8000.
- R2: A status read returns bit 15 as one and bit 31 as the OR of error bits 28..24. Those error bits are: 28 system-bus failure, 27 peripheral timeout, 26 interlock error, 25 invalid map, 24 bad datapath. Read data appears the cycle after the request.
- R3: Writing a one to any of status bits 28..24 clears that flag. Writing a zero leaves it unchanged. An event that arrives in the same cycle as its clear wins, and the flag stays set.
- R4: Status bit 20 (error interrupt enable) is the only stored read/write bit. Writes to any other non-error bit do not show on read-back.
- R5: A peripheral timeout (bit 27) captures the failing-address register (offset 0x1CA) as the address shifted right by 2, masked to 16 bits, but only if bit 27 was clear. A system-bus failure (bit 28) captures the 32-bit address register (offset 0x1CB) under the same first-occurrence rule.
- R6: An error flag that goes from clear to set raises the interrupt request if bit 20 was set. A repeat of an error that is already set does not raise it. The request stays high until the acknowledge input is pulsed.
- R7: The vector offset register (offset 0x1C9) stores and returns only bits 13..9. Every other bit reads as zero.
- R8: Datapath slots 0..5 (offsets 0x1D4..0x1D9) read back their own slot index in bits 23..21 and ignore writes.
- R9: Any read or write to datapath slots 6 or 7 (offsets 0x1DA, 0x1DB) sets the bad-datapath flag (bit 24). Such a read returns zero.
- R10: Writing status bit 17 starts an adapter-init phase of ADP_CYC cycles and drops the power-good output in the next cycle. During this phase, every offset at or above 0x1C8 reads zero and ignores writes.
- R11: A peripheral-init phase of BUS_CYC cycles follows the adapter-init phase, with the init output high. Power-good returns when this phase ends, and power-good and init are never high together.
- R12: The end of each init phase raises the interrupt request if bit 20 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Register access request, one cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ofs | input | 10 | Longword register offset |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, registered, updated only on reads |
| ev_pto | input | 1 | Peripheral-bus timeout event |
| ev_pto_addr | input | 18 | Peripheral byte address of the timeout |
| ev_sysfail | input | 1 | System-bus failure event |
| ev_sys_addr | input | 32 | System address of the failure |
| ev_ilock | input | 1 | Interlock error event |
| ev_badmap | input | 1 | Invalid map entry event |
| irq_ack | input | 1 | Clears the adapter interrupt request |
| adp_irq | output | 1 | Adapter interrupt request |
| periph_pwr_ok | output | 1 | Peripheral power-good flag |
| periph_init | output | 1 | Peripheral-bus init in progress |

## Verification
Every state change in this block takes effect at the clock edge that samples its cause. Read data, error flags, captured addresses and the interrupt request therefore settle one edge after the request or event. Power-good falls one edge after the init write. Each phase boundary lands exactly ADP_CYC or BUS_CYC edges after the one before.

A behavioural model in the bench applies the same one-edge rule. It is compared with the outputs on every falling edge, half a cycle after the outputs settle. The directed checks issue a request on one falling edge and read the result on the next, so they always sample one register stage downstream.

// File: rtl/busadp_pkg.sv
// Shared constants and types for the bus adapter control/status block.
// Assumes longword register offsets; all bit positions here are
// decoded by software, so they are fixed rather than parameters.
package busadp_pkg;
    localparam int unsigned OFS_W      = 10;
    localparam logic [OFS_W-1:0] OFS_STAT = 10'h1C8;
    localparam logic [OFS_W-1:0] OFS_VEC  = 10'h1C9;
    localparam logic [OFS_W-1:0] OFS_FPA  = 10'h1CA;
    localparam logic [OFS_W-1:0] OFS_FSA  = 10'h1CB;
    localparam logic [OFS_W-1:0] OFS_DP   = 10'h1D4;

    localparam int unsigned DP_SLOTS   = 8;
    localparam int unsigned DP_LIVE    = 6;
    localparam int unsigned DP_SEL_W   = $clog2(DP_SLOTS);
    localparam int unsigned DP_SEL_LSB = 21;

    localparam int unsigned NERR    = 5;
    localparam int unsigned ERR_LSB = 24;
    localparam int unsigned E_BDP   = 0;
    localparam int unsigned E_MAP   = 1;
    localparam int unsigned E_ILK   = 2;
    localparam int unsigned E_PTO   = 3;
    localparam int unsigned E_SYS   = 4;

    localparam int unsigned B_SUM  = 31;
    localparam int unsigned B_EIE  = 20;
    localparam int unsigned B_INIT = 17;
    localparam int unsigned B_ONE  = 15;

    localparam int unsigned VEC_LSB   = 9;
    localparam int unsigned VEC_W     = 5;
    localparam int unsigned FPA_W     = 16;
    localparam int unsigned FPA_SHIFT = 2;

    typedef enum logic [1:0] {INIT_IDLE, INIT_ADP, INIT_BUS} init_st_t;
    typedef enum logic [2:0] {RD_ZERO, RD_STAT, RD_VEC, RD_FPA, RD_FSA, RD_DP} rd_sel_t;
endpackage

// File: rtl/busadp_reg_dec.sv
// Register offset decoder. Pure combinational logic.
// Turns one host access into write strobes, a read-source select and a
// bad-datapath event. While blank_hi is set, every offset at or above
// the status register is treated as absent.
module busadp_reg_dec
    import busadp_pkg::*;
(
    input  logic                acc_en,
    input  logic                acc_wr,
    input  logic [OFS_W-1:0]    acc_ofs,
    input  logic                blank_hi,
    output logic                wr_stat,
    output logic                wr_vec,
    output logic                dp_bad,
    output rd_sel_t             rd_sel,
    output logic [DP_SEL_W-1:0] dp_idx
);
    logic                live;
    logic [DP_SLOTS-1:0] dp_hit;

    // Access is live unless the adapter-init phase blanks it.
    assign live = acc_en && !(blank_hi && (acc_ofs >= OFS_STAT));

    // One comparator per datapath slot.
    for (genvar g = 0; g < DP_SLOTS; g++) begin : g_slot
        localparam logic [OFS_W-1:0] SLOT_OFS = OFS_DP + OFS_W'(g);
        assign dp_hit[g] = (acc_ofs == SLOT_OFS);
    end

    // Encode the hit slot into an index.
    always_comb begin
        dp_idx = '0;
        for (int i = 0; i < DP_SLOTS; i++)
            if (dp_hit[i]) dp_idx = DP_SEL_W'(i);
    end

    assign wr_stat = live && acc_wr && (acc_ofs == OFS_STAT);
    assign wr_vec  = live && acc_wr && (acc_ofs == OFS_VEC);
    assign dp_bad  = live && (|dp_hit[DP_SLOTS-1:DP_LIVE]);

    // Choose the read source.
    always_comb begin
        rd_sel = RD_ZERO;
        if (live && !acc_wr) begin
            if (acc_ofs == OFS_STAT)          rd_sel = RD_STAT;
            else if (acc_ofs == OFS_VEC)      rd_sel = RD_VEC;
            else if (acc_ofs == OFS_FPA)      rd_sel = RD_FPA;
            else if (acc_ofs == OFS_FSA)      rd_sel = RD_FSA;
            else if (|dp_hit[DP_LIVE-1:0])    rd_sel = RD_DP;
        end
    end
endmodule

// File: rtl/busadp_err_latch.sv
// Sticky error flags, first-failure address capture and the adapter
// interrupt request. A flag that goes from clear to set (or the end of
// an init phase) raises the request when the enable was already set.
// A set takes priority over a same-cycle clear, and over acknowledge.
// Assumes PA_W >= FPA_W + FPA_SHIFT.
module busadp_err_latch
    import busadp_pkg::*;
#(
    parameter int unsigned PA_W = 18,
    parameter int unsigned SA_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NERR-1:0]  set_ev,
    input  logic [PA_W-1:0]  pto_addr,
    input  logic [SA_W-1:0]  sys_addr,
    input  logic             clr_wr,
    input  logic [NERR-1:0]  clr_mask,
    input  logic             eie_d,
    input  logic             phase_done,
    input  logic             irq_ack,
    output logic [NERR-1:0]  err_q,
    output logic             eie_q,
    output logic [FPA_W-1:0] fpa_q,
    output logic [SA_W-1:0]  fsa_q,
    output logic             irq_q
);
    logic [NERR-1:0] fresh;
    logic [NERR-1:0] clr;

    assign fresh = set_ev & ~err_q;
    assign clr   = clr_wr ? clr_mask : '0;

    // Error flags and the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
            eie_q <= 1'b0;
        end else begin
            err_q <= (err_q & ~clr) | set_ev;
            if (clr_wr) eie_q <= eie_d;
        end
    end

    // Capture addresses only on the first occurrence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fpa_q <= '0;
            fsa_q <= '0;
        end else begin
            if (fresh[E_PTO]) fpa_q <= pto_addr[FPA_SHIFT +: FPA_W];
            if (fresh[E_SYS]) fsa_q <= sys_addr;
        end
    end

    // Interrupt request: set has priority over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   irq_q <= 1'b0;
        else if (eie_q && ((|fresh) || phase_done))   irq_q <= 1'b1;
        else if (irq_ack)                             irq_q <= 1'b0;
    end
endmodule

// File: rtl/busadp_init_seq.sv
// Two-phase init sequencer: the adapter phase, then the peripheral-bus phase.
// Uses one down-counter shared by both phases. A start request wins over
// everything and restarts the adapter phase. Assumes ADP_CYC and
// BUS_CYC are both at least 1.
module busadp_init_seq
    import busadp_pkg::*;
#(
    parameter int unsigned ADP_CYC = 250,
    parameter int unsigned BUS_CYC = 12250
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    output init_st_t st_q,
    output logic     phase_done
);
    localparam int unsigned MAX_CYC = (ADP_CYC > BUS_CYC) ? ADP_CYC : BUS_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] ADP_LD = CNT_W'(ADP_CYC - 1);
    localparam logic [CNT_W-1:0] BUS_LD = CNT_W'(BUS_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign phase_done = (st_q != INIT_IDLE) && (cnt_q == '0) && !start;

    // Phase state and the shared counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= INIT_IDLE;
            cnt_q <= '0;
        end else if (start) begin
            st_q  <= INIT_ADP;
            cnt_q <= ADP_LD;
        end else begin
            case (st_q)
                INIT_ADP: begin
                    if (cnt_q == '0) begin
                        st_q  <= INIT_BUS;
                        cnt_q <= BUS_LD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                INIT_BUS: begin
                    if (cnt_q == '0) st_q  <= INIT_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: cnt_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/busadp_ctl_regs.sv
// Bus adapter control/status register file (top). Decodes host accesses,
// holds the vector offset and the registered read data, and connects
// the error latch and the init sequencer. Read data is updated only on
// reads and is valid the cycle after the request.
module busadp_ctl_regs
    import busadp_pkg::*;
#(
    parameter int unsigned ADP_CYC = 250,
    parameter int unsigned BUS_CYC = 12250,
    parameter int unsigned PA_W    = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic [9:0]       acc_ofs,
    input  logic [31:0]      acc_wdata,
    output logic [31:0]      acc_rdata,
    input  logic             ev_pto,
    input  logic [PA_W-1:0]  ev_pto_addr,
    input  logic             ev_sysfail,
    input  logic [31:0]      ev_sys_addr,
    input  logic             ev_ilock,
    input  logic             ev_badmap,
    input  logic             irq_ack,
    output logic             adp_irq,
    output logic             periph_pwr_ok,
    output logic             periph_init
);
    logic                wr_stat, wr_vec, dp_bad, phase_done, eie_q;
    rd_sel_t             rd_sel;
    logic [DP_SEL_W-1:0] dp_idx;
    init_st_t            st_q;
    logic [NERR-1:0]     err_q, set_ev;
    logic [FPA_W-1:0]    fpa_q;
    logic [31:0]         fsa_q, st_word, rd_val;
    logic [VEC_W-1:0]    vec_q;

    busadp_reg_dec u_dec (
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_ofs  (acc_ofs),
        .blank_hi (st_q == INIT_ADP),
        .wr_stat  (wr_stat),
        .wr_vec   (wr_vec),
        .dp_bad   (dp_bad),
        .rd_sel   (rd_sel),
        .dp_idx   (dp_idx)
    );

    // Event bits are ordered to match status bits 24..28.
    always_comb begin
        set_ev        = '0;
        set_ev[E_BDP] = dp_bad;
        set_ev[E_MAP] = ev_badmap;
        set_ev[E_ILK] = ev_ilock;
        set_ev[E_PTO] = ev_pto;
        set_ev[E_SYS] = ev_sysfail;
    end

    busadp_err_latch #(.PA_W(PA_W), .SA_W(32)) u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_ev     (set_ev),
        .pto_addr   (ev_pto_addr),
        .sys_addr   (ev_sys_addr),
        .clr_wr     (wr_stat),
        .clr_mask   (acc_wdata[ERR_LSB +: NERR]),
        .eie_d      (acc_wdata[B_EIE]),
        .phase_done (phase_done),
        .irq_ack    (irq_ack),
        .err_q      (err_q),
        .eie_q      (eie_q),
        .fpa_q      (fpa_q),
        .fsa_q      (fsa_q),
        .irq_q      (adp_irq)
    );

    busadp_init_seq #(.ADP_CYC(ADP_CYC), .BUS_CYC(BUS_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (wr_stat && acc_wdata[B_INIT]),
        .st_q       (st_q),
        .phase_done (phase_done)
    );

    assign periph_pwr_ok = (st_q == INIT_IDLE);
    assign periph_init   = (st_q == INIT_BUS);

    // Vector offset register.
    always_ff @(posedge clk) begin
        if (!rst_n)      vec_q <= '0;
        else if (wr_vec) vec_q <= acc_wdata[VEC_LSB +: VEC_W];
    end

    // Assemble the status word and the read mux.
    always_comb begin
        st_word                     = '0;
        st_word[ERR_LSB +: NERR]    = err_q;
        st_word[B_EIE]              = eie_q;
        st_word[B_ONE]              = 1'b1;
        st_word[B_SUM]              = |err_q;
        case (rd_sel)
            RD_STAT: rd_val = st_word;
            RD_VEC:  rd_val = 32'(vec_q) << VEC_LSB;
            RD_FPA:  rd_val = 32'(fpa_q);
            RD_FSA:  rd_val = fsa_q;
            RD_DP:   rd_val = 32'(dp_idx) << DP_SEL_LSB;
            default: rd_val = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                  acc_rdata <= '0;
        else if (acc_en && !acc_wr)  acc_rdata <= rd_val;
    end
endmodule

// File: rtl/busadp_ctl_chk.sv
// Checker for busadp_ctl_regs. It observes only the top-level ports
// and is attached to the top module with bind.
module busadp_ctl_chk
    import busadp_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        acc_en,
    input logic        acc_wr,
    input logic [9:0]  acc_ofs,
    input logic [31:0] acc_wdata,
    input logic [31:0] acc_rdata,
    input logic        irq_ack,
    input logic        adp_irq,
    input logic        periph_pwr_ok,
    input logic        periph_init
);
    logic rd_req;
    assign rd_req = acc_en && !acc_wr;

    // R2: status reads carry the one bit and a consistent summary (or are blanked).
    p_stat_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && acc_ofs == OFS_STAT) |=>
        (acc_rdata == '0 || (acc_rdata[B_ONE] && acc_rdata[B_SUM] == |acc_rdata[28:24])));

    // R7: only vector bits 13..9 can read back.
    p_vec_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && acc_ofs == OFS_VEC) |=> ((acc_rdata & ~32'h0000_3E00) == '0));

    // R5: the failing peripheral address fits in 16 bits.
    p_fpa_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && acc_ofs == OFS_FPA) |=> (acc_rdata[31:16] == '0));

    // R8: slot 3 reads its own index.
    p_dp_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && acc_ofs == 10'h1D7) |=> (acc_rdata == 32'h0060_0000));

    // R6: an unacknowledged request stays up.
    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adp_irq && !irq_ack) |=> adp_irq);

    // R10: the init command drops power-good in the next cycle.
    p_pwr_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_ofs == OFS_STAT && acc_wdata[B_INIT] && periph_pwr_ok)
        |=> !periph_pwr_ok);

    // R11: power-good and peripheral init never overlap.
    p_pwr_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(periph_pwr_ok && periph_init));

    // R11: power-good returns only from the peripheral-init phase.
    p_pwr_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(periph_pwr_ok) |-> $past(periph_init));
endmodule

bind busadp_ctl_regs busadp_ctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_en        (acc_en),
    .acc_wr        (acc_wr),
    .acc_ofs       (acc_ofs),
    .acc_wdata     (acc_wdata),
    .acc_rdata     (acc_rdata),
    .irq_ack       (irq_ack),
    .adp_irq       (adp_irq),
    .periph_pwr_ok (periph_pwr_ok),
    .periph_init   (periph_init)
);

// File: tb/test_busadp_ctl_regs.sv
// Bench for busadp_ctl_regs. A behavioural model runs in parallel and is
// compared with the outputs on every falling edge. Directed checks
// cover each requirement.
module test_busadp_ctl_regs;
    localparam int ADP = 250;
    localparam int BUS = 12250;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0;
    logic [9:0]  acc_ofs = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        ev_pto = 1'b0, ev_sysfail = 1'b0, ev_ilock = 1'b0, ev_badmap = 1'b0;
    logic [17:0] ev_pto_addr = '0;
    logic [31:0] ev_sys_addr = '0;
    logic        irq_ack = 1'b0;
    logic        adp_irq, periph_pwr_ok, periph_init;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    busadp_ctl_regs #(.ADP_CYC(ADP), .BUS_CYC(BUS)) i_busadp_ctl_regs (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_ofs(acc_ofs), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .ev_pto(ev_pto), .ev_pto_addr(ev_pto_addr), .ev_sysfail(ev_sysfail),
        .ev_sys_addr(ev_sys_addr), .ev_ilock(ev_ilock), .ev_badmap(ev_badmap),
        .irq_ack(irq_ack), .adp_irq(adp_irq), .periph_pwr_ok(periph_pwr_ok),
        .periph_init(periph_init)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural model ----------------
    logic [4:0]  m_err = '0;
    logic        m_eie = 1'b0, m_irq = 1'b0;
    logic [31:0] m_fpa = '0, m_fsa = '0, m_rdata = '0;
    logic [4:0]  m_vec = '0;
    int          m_st = 0, m_rem = 0;
    string       m_rtag = "R1";
    bit          started = 0;

    always @(posedge clk) begin
        logic blank, live, start, done;
        logic [4:0] set, newe, clr;
        int o;
        started <= 1;
        o = int'(acc_ofs);
        if (!rst_n) begin
            m_err = '0; m_eie = 0; m_irq = 0; m_fpa = '0; m_fsa = '0;
            m_rdata = '0; m_vec = '0; m_st = 0; m_rem = 0; m_rtag = "R1";
        end else begin
            blank = (m_st == 1) && (o >= 'h1C8);
            live  = acc_en && !blank;
            if (acc_en && !acc_wr) begin
                if (!live) begin m_rdata = '0; m_rtag = "R10"; end
                else if (o == 'h1C8) begin
                    m_rdata = {(m_err != 0), 2'b00, m_err, 3'b000, m_eie, 4'b0, 1'b1, 15'b0};
                    m_rtag = "R2";
                end
                else if (o == 'h1C9) begin m_rdata = {18'b0, m_vec, 9'b0}; m_rtag = "R7"; end
                else if (o == 'h1CA) begin m_rdata = m_fpa; m_rtag = "R5"; end
                else if (o == 'h1CB) begin m_rdata = m_fsa; m_rtag = "R5"; end
                else if (o >= 'h1D4 && o <= 'h1D9) begin m_rdata = (o - 'h1D4) << 21; m_rtag = "R8"; end
                else begin m_rdata = '0; m_rtag = "R9"; end
            end
            set = {ev_sysfail, ev_pto, ev_ilock, ev_badmap, live && (o == 'h1DA || o == 'h1DB)};
            newe = set & ~m_err;
            clr = (live && acc_wr && o == 'h1C8) ? acc_wdata[28:24] : 5'b0;
            if (newe[3]) m_fpa = {16'b0, ev_pto_addr[17:2]};
            if (newe[4]) m_fsa = ev_sys_addr;
            start = live && acc_wr && o == 'h1C8 && acc_wdata[17];
            done = 0;
            if (start) begin m_st = 1; m_rem = ADP; end
            else if (m_st != 0) begin
                m_rem--;
                if (m_rem == 0) begin
                    done = 1;
                    if (m_st == 1) begin m_st = 2; m_rem = BUS; end
                    else m_st = 0;
                end
            end
            if (m_eie && (newe != 0 || done)) m_irq = 1;
            else if (irq_ack) m_irq = 0;
            m_err = (m_err & ~clr) | set;
            if (live && acc_wr && o == 'h1C8) m_eie = acc_wdata[20];
            if (live && acc_wr && o == 'h1C9) m_vec = acc_wdata[13:9];
        end
    end

    // Compare the outputs with the model every cycle.
    always @(negedge clk) begin
        if (started) begin
            chk({m_rtag, " rdata"}, acc_rdata, m_rdata);
            chk("R6 irq", {31'b0, adp_irq}, {31'b0, m_irq});
            chk("R11 pwr_ok", {31'b0, periph_pwr_ok}, {31'b0, m_st == 0});
            chk("R11 init", {31'b0, periph_init}, {31'b0, m_st == 2});
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic do_rd(input logic [9:0] o, output logic [31:0] d);
        @(negedge clk); acc_en = 1; acc_wr = 0; acc_ofs = o;
        @(negedge clk); acc_en = 0; d = acc_rdata;
    endtask

    task automatic do_wr(input logic [9:0] o, input logic [31:0] v);
        @(negedge clk); acc_en = 1; acc_wr = 1; acc_ofs = o; acc_wdata = v;
        @(negedge clk); acc_en = 0; acc_wr = 0;
    endtask

    task automatic pulse_pto(input logic [17:0] a);
        @(negedge clk); ev_pto = 1; ev_pto_addr = a;
        @(negedge clk); ev_pto = 0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (60000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 irq", {31'b0, adp_irq}, 32'd0);
        chk("R1 pwr_ok", {31'b0, periph_pwr_ok}, 32'd1);
        do_rd(10'h1C8, d); chk("R1 status", d, 32'h0000_8000);
        // R4: only the enable is stored
        do_wr(10'h1C8, 32'h0010_0001);
        do_rd(10'h1C8, d); chk("R4 status", d, 32'h0010_8000);
        // R5 and R6: timeout capture and interrupt
        pulse_pto(18'h2ABCD);
        chk("R6 irq raised", {31'b0, adp_irq}, 32'd1);
        do_rd(10'h1C8, d); chk("R2 status summary", d, 32'h8810_8000);
        do_rd(10'h1CA, d); chk("R5 fpa", d, 32'h0000_AAF3);
        pulse_ack();
        chk("R6 irq acked", {31'b0, adp_irq}, 32'd0);
        pulse_pto(18'h00010);
        chk("R6 repeat no irq", {31'b0, adp_irq}, 32'd0);
        do_rd(10'h1CA, d); chk("R5 fpa kept", d, 32'h0000_AAF3);
        // R3: write-one-to-clear
        do_wr(10'h1C8, 32'h0010_0000);
        do_rd(10'h1C8, d); chk("R3 zero keeps", d, 32'h8810_8000);
        do_wr(10'h1C8, 32'h0810_0000);
        do_rd(10'h1C8, d); chk("R3 one clears", d, 32'h0010_8000);
        // R5: system failure capture, plus other events
        @(negedge clk); ev_sysfail = 1; ev_sys_addr = 32'h1234_5678; ev_ilock = 1; ev_badmap = 1;
        @(negedge clk); ev_sysfail = 0; ev_ilock = 0; ev_badmap = 0; ev_sys_addr = 32'hDEAD_BEEF;
        @(negedge clk); ev_sysfail = 1;
        @(negedge clk); ev_sysfail = 0;
        do_rd(10'h1CB, d); chk("R5 fsa first", d, 32'h1234_5678);
        do_rd(10'h1C8, d); chk("R2 multi errors", d, 32'h9610_8000);
        pulse_ack();
        do_wr(10'h1C8, 32'h1F00_0000);
        do_rd(10'h1C8, d); chk("R3 clear all", d, 32'h0000_8000);
        @(negedge clk); ev_ilock = 1;
        @(negedge clk); ev_ilock = 0;
        chk("R6 disabled no irq", {31'b0, adp_irq}, 32'd0);
        do_wr(10'h1C8, 32'h0400_0000);
        // R7: vector bits
        do_wr(10'h1C9, 32'hFFFF_FFFF);
        do_rd(10'h1C9, d); chk("R7 vector", d, 32'h0000_3E00);
        // R8: datapath slots
        do_rd(10'h1D6, d); chk("R8 slot2", d, 32'h0040_0000);
        do_wr(10'h1D6, 32'h0000_0000);
        do_rd(10'h1D6, d); chk("R8 slot2 after write", d, 32'h0040_0000);
        do_rd(10'h1D9, d); chk("R8 slot5", d, 32'h00A0_0000);
        // R9: bad datapath slots
        do_rd(10'h1DA, d); chk("R9 slot6 read zero", d, 32'h0);
        do_rd(10'h1C8, d); chk("R9 bdp after read", d, 32'h8100_8000);
        do_wr(10'h1C8, 32'h0100_0000);
        do_wr(10'h1DB, 32'h1);
        do_rd(10'h1C8, d); chk("R9 bdp after write", d, 32'h8100_8000);
        do_wr(10'h1C8, 32'h0110_0000);
        // R10: init sequence, phase one
        do_wr(10'h1C8, 32'h0012_0000);
        chk("R10 pwr dropped", {31'b0, periph_pwr_ok}, 32'd0);
        do_rd(10'h1C8, d); chk("R10 blanked read", d, 32'h0);
        do_wr(10'h1C9, 32'h0);
        repeat (ADP) @(negedge clk);
        chk("R11 bus init", {31'b0, periph_init}, 32'd1);
        chk("R12 irq phase one", {31'b0, adp_irq}, 32'd1);
        pulse_ack();
        do_rd(10'h1C9, d); chk("R10 write ignored", d, 32'h0000_3E00);
        // R11: phase two
        repeat (BUS) @(negedge clk);
        chk("R11 pwr back", {31'b0, periph_pwr_ok}, 32'd1);
        chk("R11 init done", {31'b0, periph_init}, 32'd0);
        chk("R12 irq phase two", {31'b0, adp_irq}, 32'd1);
        do_rd(10'h1C8, d); chk("R11 access restored", d, 32'h0010_8000);
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule